// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This block is an 8-bit up-counter for a small controller core. It has two count sources. In timer mode it counts a tick that a divide-by-32 prescaler makes from the machine-cycle strobe. In event mode it counts falling edges of an external pin. The pin is sampled once per machine cycle, at the state-phase strobe. The core can load the count at any time and can read it at any time. Three command pulses drive the block: start as timer, start as event counter, and stop.

When the count wraps from FF to 00, the block sets a sticky overflow flag and raises a one-clock request for the interrupt controller. Counting then goes on. The core reads the flag through a test-and-clear pulse, so testing the flag also clears it.

The machine-cycle generator is outside this block. It delivers `cyc_en`, one clock per machine cycle, and `phase_en`, one clock at the fixed sampling state of each machine cycle.

Top module: `tick_event_counter`

## Requirements
- R1: After reset, `ovf_flag` and `ovf_pulse` are 0 and counting is halted. Reset does not clear `count`. While halted, a loaded value stays unchanged under strobes and pin edges.
- R2: A `load_en` clock writes `load_data` into the counter. The value appears on `count` on the following clock and stays there until the next load or increment.
- R3: A `start_tmr` pulse selects timer mode. The first increment comes at the clock that carries the 32nd `cyc_en` strobe after the start clock, and one more follows every 32 strobes after that. Clocks without `cyc_en` do not advance the prescaler.
- R4: Every `start_tmr` clears the prescaler, including one given while the timer is already running. After a restart the count waits a full 32 strobes.
- R5: A `start_evt` pulse selects event mode. The count advances by one at each `phase_en` clock where `evt_pin` is 0 and the previous pin sample was 1. Rising edges do not count. A pulse that starts and ends between two `phase_en` clocks is not seen.
- R6: A `stop` pulse halts counting in either mode. Counting resumes only after `start_tmr` or `start_evt`.
- R7: An increment from FF to 00 sets `ovf_flag` and gives exactly one clock of `ovf_pulse`, both on the clock in which `count` becomes 00. Counting then continues from 00.
- R8: A `flag_test` pulse clears `ovf_flag` on the next clock.
- R9: If `load_en` and an increment fall in the same clock, the loaded value wins and the increment is lost.
- R10: If `flag_test` falls in the same clock as a wrap, `ovf_flag` stays set.
- R11: Command priority is `stop` over `start_tmr` over `start_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe, one clock per machine cycle |
| phase_en | input | 1 | Sampling-state strobe, one clock per machine cycle |
| evt_pin | input | 1 | External event input, already synchronised |
| load_en | input | 1 | Write `load_data` into the counter |
| load_data | input | 8 | Value to load |
| start_tmr | input | 1 | Start timer mode and clear the prescaler |
| start_evt | input | 1 | Start event mode |
| stop | input | 1 | Halt counting |
| flag_test | input | 1 | Test-and-clear pulse for the overflow flag |
| count | output | 8 | Current count value (read port) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-clock overflow request to the interrupt controller |

## Verification
Two pairs of functions can collide in one clock. The first pair is a load and an increment. The second pair is a flag test and a wrap.

Each collision is provoked by setting up the previous pin sample as high in event mode. The next phase strobe, with the pin low, then lands in the same clock as `load_en` or as `flag_test`. For the load case, `count` must show the loaded value rather than that value plus one. For the flag case, the overflow flag must still read 1 on the clock after the wrap. A separate flag test beforehand shows that the clear works on its own.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    TEC_IDLE  = 2'd0,
    TEC_TIMER = 2'd1,
    TEC_EVENT = 2'd2
  } tec_mode_e;
endpackage

// File: rtl/tec_mode_ctrl.sv
module tec_mode_ctrl
  import tec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_tmr,
  input  logic      start_evt,
  input  logic      stop,
  output tec_mode_e mode_q
);
  tec_mode_e mode_d;

  // Stop has the highest priority, then timer start, then event start.
  always_comb begin
    mode_d = mode_q;
    if (stop)           mode_d = TEC_IDLE;
    else if (start_tmr) mode_d = TEC_TIMER;
    else if (start_evt) mode_d = TEC_EVENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TEC_IDLE;
    else        mode_q <= mode_d;
  end

  p_stop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (mode_q == TEC_IDLE));
  p_tmr_over_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_tmr && !stop) |=> (mode_q == TEC_TIMER));
endmodule

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cyc_en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          adv;

  // A clear in the same clock suppresses the strobe.
  assign adv  = run && cyc_en && !clr;
  assign tick = adv && (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (adv) pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
  p_tick_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/tec_edge_sampler.sv
module tec_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic phase_en,
  input  logic pin,
  output logic fall
);
  logic smp_q, smp_d;

  // The pin is looked at only on the phase strobe. The held sample starts high.
  assign smp_d = phase_en ? pin : smp_q;
  assign fall  = run && phase_en && smp_q && !pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b1;
    else        smp_q <= smp_d;
  end

  p_fall_stores_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !smp_q);
  p_sample_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_en |=> $stable(smp_q));
endmodule

// File: rtl/tec_count_core.sv
module tec_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         flag_test,
  output logic [W-1:0] cnt_q,
  output logic         flag_q,
  output logic         pulse_q
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_d;
  logic         bump, wrap, flag_d;

  assign bump = inc && !load_en;
  assign wrap = bump && (cnt_q == MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)   cnt_d = load_data;
    else if (bump) cnt_d = cnt_q + 1'b1;
  end

  // A wrap in the same clock as a test keeps the flag set.
  always_comb begin
    flag_d = flag_q;
    if (wrap)           flag_d = 1'b1;
    else if (flag_test) flag_d = 1'b0;
  end

  // The count value is not reset.
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= wrap;
    end
  end

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_data)));
  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && cnt_q == MAX) |=> (flag_q && pulse_q && cnt_q == '0));
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_test_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_test && !(inc && !load_en && cnt_q == MAX)) |=> !flag_q);
  p_test_vs_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_test && inc && !load_en && cnt_q == MAX) |=> flag_q);
endmodule

// File: rtl/tick_event_counter.sv
module tick_event_counter
  import tec_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRESCALE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             phase_en,
  input  logic             evt_pin,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_data,
  input  logic             start_tmr,
  input  logic             start_evt,
  input  logic             stop,
  input  logic             flag_test,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             ovf_pulse
);
  // Reset asserts asynchronously and is released synchronously.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  tec_mode_e mode_q;
  logic      tmr_run, evt_run, tick, fall;

  tec_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start_tmr (start_tmr),
    .start_evt (start_evt),
    .stop      (stop),
    .mode_q    (mode_q)
  );

  assign tmr_run = (mode_q == TEC_TIMER);
  assign evt_run = (mode_q == TEC_EVENT);

  tec_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .run    (tmr_run),
    .cyc_en (cyc_en),
    .clr    (start_tmr),
    .tick   (tick)
  );

  tec_edge_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .run      (evt_run),
    .phase_en (phase_en),
    .pin      (evt_pin),
    .fall     (fall)
  );

  tec_count_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .inc       (tick | fall),
    .load_en   (load_en),
    .load_data (load_data),
    .flag_test (flag_test),
    .cnt_q     (count),
    .flag_q    (ovf_flag),
    .pulse_q   (ovf_pulse)
  );

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((mode_q == TEC_IDLE) && !load_en) |=> $stable(count));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_i |-> (!ovf_flag && !ovf_pulse));
endmodule

// File: tb/tick_event_counter_tb.sv
module tick_event_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, phase_en, evt_pin, load_en, start_tmr, start_evt, stop, flag_test;
  logic [7:0] load_data;
  logic [7:0] count;
  logic       ovf_flag, ovf_pulse;
  logic       sparse;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  tick_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .phase_en(phase_en),
    .evt_pin(evt_pin), .load_en(load_en), .load_data(load_data),
    .start_tmr(start_tmr), .start_evt(start_evt), .stop(stop),
    .flag_test(flag_test), .count(count), .ovf_flag(ovf_flag),
    .ovf_pulse(ovf_pulse)
  );

  // The machine-cycle strobe is either always on or on every other clock.
  always @(negedge clk) cyc_en <= sparse ? ~cyc_en : 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [7:0] v);
    @(negedge clk); load_en = 1'b1; load_data = v;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic cmd(input logic t, input logic e, input logic s);
    @(negedge clk); start_tmr = t; start_evt = e; stop = s;
    @(negedge clk); start_tmr = 0; start_evt = 0; stop = 0;
  endtask

  task automatic sample(input logic v);
    @(negedge clk); evt_pin = v; phase_en = 1'b1;
    @(negedge clk); phase_en = 1'b0;
  endtask

  task automatic t_reset_r1();
    chk("R1 flag after reset", ovf_flag, 0);
    chk("R1 pulse after reset", ovf_pulse, 0);
    do_load(8'h05);
    chk("R2 load visible", count, 8'h05);
    idle(40); sample(1); sample(0); sample(1); sample(0);
    chk("R1 halted after reset", count, 8'h05);
  endtask

  task automatic t_timer_r3();
    do_load(8'h10);
    cmd(1, 0, 0);
    idle(31);
    chk("R3 no step before 32 strobes", count, 8'h10);
    idle(1);
    chk("R3 step on 32nd strobe", count, 8'h11);
    idle(32);
    chk("R3 second step", count, 8'h12);
    cmd(0, 0, 1);
    sparse = 1'b1;
    do_load(8'h20);
    cmd(1, 0, 0);
    idle(60);
    chk("R3 sparse strobes no step yet", count, 8'h20);
    idle(10);
    chk("R3 sparse strobes one step", count, 8'h21);
    cmd(0, 0, 1);
    sparse = 1'b0;
  endtask

  task automatic t_restart_r4();
    do_load(8'h30);
    cmd(1, 0, 0);
    idle(20);
    cmd(1, 0, 0);
    idle(30);
    chk("R4 restart clears prescaler", count, 8'h30);
    idle(2);
    chk("R4 step after full period", count, 8'h31);
    cmd(0, 0, 1);
  endtask

  task automatic t_event_r5();
    cmd(0, 1, 0);
    do_load(8'h40);
    sample(1); sample(0);
    chk("R5 falling edge counts", count, 8'h41);
    sample(0); sample(1);
    chk("R5 low hold and rising edge ignored", count, 8'h41);
    @(negedge clk); evt_pin = 1'b0;
    @(negedge clk); evt_pin = 1'b1;
    @(negedge clk);
    sample(1);
    chk("R5 pulse between strobes unseen", count, 8'h41);
    sample(0);
    chk("R5 second edge", count, 8'h42);
  endtask

  task automatic t_stop_r6();
    cmd(0, 0, 1);
    sample(1); sample(0); sample(1); sample(0);
    chk("R6 stop halts event mode", count, 8'h42);
    cmd(1, 0, 0);
    idle(10);
    cmd(0, 0, 1);
    idle(70);
    chk("R6 stop halts timer mode", count, 8'h42);
    cmd(0, 1, 0);
    sample(1); sample(0);
    chk("R6 resumes after start", count, 8'h43);
  endtask

  task automatic t_wrap_r7();
    do_load(8'hFF);
    sample(1); sample(0);
    chk("R7 wrap to 00", count, 8'h00);
    chk("R7 flag set on wrap", ovf_flag, 1);
    chk("R7 pulse on wrap", ovf_pulse, 1);
    idle(1);
    chk("R7 pulse one clock", ovf_pulse, 0);
    sample(1); sample(0);
    chk("R7 counting continues", count, 8'h01);
    chk("R7 flag sticky", ovf_flag, 1);
    @(negedge clk); flag_test = 1'b1;
    @(negedge clk); flag_test = 1'b0;
    chk("R8 test clears flag", ovf_flag, 0);
  endtask

  task automatic t_collide_r9_r10();
    do_load(8'h50);
    sample(1);
    @(negedge clk); evt_pin = 0; phase_en = 1; load_en = 1; load_data = 8'h60;
    @(negedge clk); phase_en = 0; load_en = 0;
    chk("R9 load wins over increment", count, 8'h60);
    do_load(8'hFF);
    sample(1);
    @(negedge clk); evt_pin = 0; phase_en = 1; flag_test = 1;
    @(negedge clk); phase_en = 0; flag_test = 0;
    chk("R10 wrap count", count, 8'h00);
    chk("R10 flag stays set", ovf_flag, 1);
  endtask

  task automatic t_priority_r11();
    cmd(0, 0, 1);
    do_load(8'h70);
    cmd(1, 0, 1);
    idle(40); sample(1); sample(0);
    chk("R11 stop beats start", count, 8'h70);
    cmd(1, 1, 0);
    sample(1); sample(0);
    chk("R11 timer beats event, edge ignored", count, 8'h70);
    idle(40);
    chk("R11 timer running", count, 8'h71);
    cmd(0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; sparse = 0; cyc_en = 1; phase_en = 0; evt_pin = 1;
    load_en = 0; load_data = 0; start_tmr = 0; start_evt = 0; stop = 0; flag_test = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    t_reset_r1();
    t_timer_r3();
    t_restart_r4();
    t_event_r5();
    t_stop_r6();
    t_wrap_r7();
    t_collide_r9_r10();
    t_priority_r11();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule